// File: doc/BRIEF.md
# Operating-System Timer with Match Interrupts and Watchdog

This block keeps one free-running counter and compares it against a small set of match registers. The counter advances by one on every clock in which the `tick` input is high; the tick is generated outside the block. Software reaches every register over a simple single-cycle register bus. Software can also load the counter with any value, and counting then continues from that value.

Each match channel compares its register with the counter. A channel fires when the counter takes the match value, either by counting or by a load. A firing channel sets its status bit only when its interrupt enable is set, and each status bit drives its own interrupt line. Software clears status bits by writing ones to them. The highest match channel can also act as a watchdog. When it fires while the watchdog is armed, the block issues a one-cycle reset request and disarms itself.

Top module: `ostm_timer`

## Requirements
- R1: After reset, the counter, every match register, the status bits, the interrupt enable and the watchdog register all read as zero, and `irq`, `rst_req` and `bus_err` are low.
- R2: The counter adds one on each clock edge where `tick` is high and holds its value otherwise. It wraps from 0xFFFFFFFF to 0.
- R3: A bus write to offset 0x10 loads the counter with the written data. The load wins over a `tick` in the same cycle, and later ticks count up from the loaded value.
- R4: Channel k (match register at offset 4*k, k = 0..3) fires when the counter changes, by tick or load, to a value equal to match register k. On a fire, status bit k is set only if interrupt-enable bit k is 1. Writing a match register with the counter's current value does not cause a fire.
- R5: `irq[k]` always equals status bit k. Status reads at offset 0x14 with channel k in bit k.
- R6: A write to the status register clears the status bits whose written bit is 1. Written zeros have no effect. If a channel fires in the same cycle as the write that clears it, the bit stays set.
- R7: A write to the interrupt-enable register (offset 0x1C) stores only data bits 11:0. A read of that register returns those bits with zeros above them.
- R8: The watchdog register is at offset 0x18, and bit 0 arms it. If channel 3 fires while bit 0 is 1, `rst_req` goes high for exactly one cycle and the watchdog register becomes 0, whatever the state of interrupt-enable bit 3. If channel 3 fires while bit 0 is 0, no request is made.
- R9: An access to any other offset, including an offset that is not a multiple of 4, raises `bus_err` for one cycle. A read at such an offset returns 0, and a write there changes no register.
- R10: A read (`bus_sel` high, `bus_wr` low) returns the register value from before the access edge on `bus_rdata`, in the cycle after that edge. `bus_rdata` is 0 in the cycle after a write or after an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count enable: the counter advances on each edge where this is high |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle after a read |
| bus_err | output | 1 | One-cycle flag for an access to an unmapped offset |
| irq | output | 4 | Per-channel interrupt lines, equal to the status bits |
| rst_req | output | 1 | One-cycle watchdog reset request |

## Verification
The bench uses the default parameters: a 32-bit counter and match registers, four channels, a 12-bit enable register and 8-bit offsets. With these values it can load the counter with 0xFFFFFFFF, so a single tick reaches the wrap to zero and a match at zero. Random match values are placed a few ticks ahead of the counter, so fires on channel 3 come often. This lets armed and disarmed watchdog fires, and fires that collide with status writes and counter loads, all occur within a short run.

// File: rtl/ostm_pkg.sv
// Package ostm_pkg: register offsets and the decoded-access type shared by
// the timer modules. Assumes word-aligned byte offsets.
package ostm_pkg;

    localparam int OSTM_DATA_W = 32;
    localparam int OSTM_ADDR_W = 8;
    localparam int OSTM_NUM_CH = 4;
    localparam int OSTM_IEN_W  = 12;

    localparam logic [7:0] OFF_COUNT  = 8'h10;
    localparam logic [7:0] OFF_STATUS = 8'h14;
    localparam logic [7:0] OFF_WDOG   = 8'h18;
    localparam logic [7:0] OFF_IEN    = 8'h1C;

    typedef enum logic [2:0] {
        RS_MATCH,
        RS_COUNT,
        RS_STATUS,
        RS_WDOG,
        RS_IEN,
        RS_NONE
    } ostm_reg_e;

    typedef struct packed {
        ostm_reg_e  kind;
        logic [7:0] ch;
    } ostm_dec_t;

endpackage

// File: rtl/ostm_decode.sv
// Module ostm_decode: turns a byte offset into a register kind and a channel
// index. Match registers sit at 4*k for k below NUM_CH. Unaligned or unknown
// offsets decode to RS_NONE. Assumes NUM_CH <= 4, so the match block does not
// overlap the fixed registers.
module ostm_decode
    import ostm_pkg::*;
#(
    parameter int ADDR_W = OSTM_ADDR_W,
    parameter int NUM_CH = OSTM_NUM_CH
) (
    input  logic [ADDR_W-1:0] addr,
    output ostm_dec_t         dec
);

    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    assign word = addr[ADDR_W-1:2];

    // Purpose: classify the offset into one register kind.
    always_comb begin
        dec.kind = RS_NONE;
        dec.ch   = '0;
        if (addr[1:0] == 2'b00) begin
            if (word < WORD_W'(NUM_CH)) begin
                dec.kind = RS_MATCH;
                dec.ch   = 8'(word);
            end else if (addr == ADDR_W'(OFF_COUNT)) begin
                dec.kind = RS_COUNT;
            end else if (addr == ADDR_W'(OFF_STATUS)) begin
                dec.kind = RS_STATUS;
            end else if (addr == ADDR_W'(OFF_WDOG)) begin
                dec.kind = RS_WDOG;
            end else if (addr == ADDR_W'(OFF_IEN)) begin
                dec.kind = RS_IEN;
            end
        end
    end

endmodule

// File: rtl/ostm_counter.sv
// Module ostm_counter: free-running up counter with a load port. A load wins
// over a tick in the same cycle. Exposes the next value and an update flag so
// that match channels compare against the value the counter is taking.
module ostm_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_nx,
    output logic         cnt_upd
);

    // Purpose: choose the next count (load, then tick, then hold).
    always_comb begin
        if (load) begin
            cnt_nx  = load_val;
            cnt_upd = 1'b1;
        end else if (tick) begin
            cnt_nx  = cnt_q + W'(1);
            cnt_upd = 1'b1;
        end else begin
            cnt_nx  = cnt_q;
            cnt_upd = 1'b0;
        end
    end

    // Purpose: register the count.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_nx;
    end

endmodule

// File: rtl/ostm_match_chan.sv
// Module ostm_match_chan: one match register with an equality compare. It
// fires only in a cycle where the counter changes to the match value, so
// writing the match register to the current count does not fire it.
module ostm_match_chan #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_val,
    input  logic [W-1:0] cnt_nx,
    input  logic         cnt_upd,
    output logic [W-1:0] match_q,
    output logic         fire
);

    // Purpose: hold the software-written match value.
    always_ff @(posedge clk) begin
        if (!rst_n)     match_q <= '0;
        else if (wr_en) match_q <= wr_val;
    end

    // Purpose: flag the cycle in which the counter takes the match value.
    always_comb begin
        fire = cnt_upd && (cnt_nx == match_q);
    end

endmodule

// File: rtl/ostm_status.sv
// Module ostm_status: interrupt-enable register and write-one-to-clear status
// bits. A fire that is enabled sets its bit; a set in the same cycle wins over
// a clear. Assumes IEN_W >= NUM_CH and W >= IEN_W.
module ostm_status #(
    parameter int NUM_CH = 4,
    parameter int IEN_W  = 12,
    parameter int W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] fire,
    input  logic              ien_wr,
    input  logic              stat_wr,
    input  logic [W-1:0]      wdata,
    output logic [IEN_W-1:0]  ien_q,
    output logic [NUM_CH-1:0] stat_q
);

    logic [NUM_CH-1:0] clr_mask;
    logic [NUM_CH-1:0] set_mask;

    // Purpose: form the clear and set masks for this cycle.
    always_comb begin
        clr_mask = stat_wr ? wdata[NUM_CH-1:0] : '0;
        set_mask = fire & ien_q[NUM_CH-1:0];
    end

    // Purpose: keep only the low IEN_W bits of an enable write.
    always_ff @(posedge clk) begin
        if (!rst_n)      ien_q <= '0;
        else if (ien_wr) ien_q <= wdata[IEN_W-1:0];
    end

    // Purpose: update the status bits, with a set winning over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_mask) | set_mask;
    end

endmodule

// File: rtl/ostm_timer.sv
// Module ostm_timer: top level of the operating-system timer. It holds the
// bus decode, the counter, NUM_CH match channels, the status and enable
// registers, and the watchdog on channel WDOG_CH. Reads are registered and
// appear one cycle after the access. Assumes tick is synchronous to clk.
module ostm_timer
    import ostm_pkg::*;
#(
    parameter int DATA_W  = OSTM_DATA_W,
    parameter int ADDR_W  = OSTM_ADDR_W,
    parameter int NUM_CH  = OSTM_NUM_CH,
    parameter int IEN_W   = OSTM_IEN_W,
    parameter int WDOG_CH = NUM_CH - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    output logic [NUM_CH-1:0] irq,
    output logic              rst_req
);

    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    ostm_dec_t          dec;
    logic               acc_wr;
    logic               acc_rd;
    logic [DATA_W-1:0]  cnt_q;
    logic [DATA_W-1:0]  cnt_nx;
    logic               cnt_upd;
    logic [DATA_W-1:0]  match_q [NUM_CH];
    logic [NUM_CH-1:0]  fire;
    logic [IEN_W-1:0]   ien_q;
    logic [NUM_CH-1:0]  stat_q;
    logic [DATA_W-1:0]  wdog_q;
    logic               wd_fire;
    logic [DATA_W-1:0]  rd_mux;
    logic [DATA_W-1:0]  rdata_q;
    logic               err_q;
    logic               rst_req_q;

    assign acc_wr = bus_sel && bus_wr;
    assign acc_rd = bus_sel && !bus_wr;

    ostm_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) dec_i (
        .addr (bus_addr),
        .dec  (dec)
    );

    ostm_counter #(.W(DATA_W)) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (acc_wr && dec.kind == RS_COUNT),
        .load_val (bus_wdata),
        .cnt_q    (cnt_q),
        .cnt_nx   (cnt_nx),
        .cnt_upd  (cnt_upd)
    );

    for (genvar k = 0; k < NUM_CH; k++) begin : g_chan
        ostm_match_chan #(.W(DATA_W)) chan_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (acc_wr && dec.kind == RS_MATCH && dec.ch == 8'(k)),
            .wr_val  (bus_wdata),
            .cnt_nx  (cnt_nx),
            .cnt_upd (cnt_upd),
            .match_q (match_q[k]),
            .fire    (fire[k])
        );
    end

    ostm_status #(.NUM_CH(NUM_CH), .IEN_W(IEN_W), .W(DATA_W)) stat_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (fire),
        .ien_wr  (acc_wr && dec.kind == RS_IEN),
        .stat_wr (acc_wr && dec.kind == RS_STATUS),
        .wdata   (bus_wdata),
        .ien_q   (ien_q),
        .stat_q  (stat_q)
    );

    assign wd_fire = fire[WDOG_CH] && wdog_q[0];

    // Purpose: watchdog arm register; a watchdog fire disarms it ahead of a write.
    always_ff @(posedge clk) begin
        if (!rst_n)                            wdog_q <= '0;
        else if (wd_fire)                      wdog_q <= '0;
        else if (acc_wr && dec.kind == RS_WDOG) wdog_q <= bus_wdata;
    end

    // Purpose: one-cycle reset request on a watchdog fire.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_req_q <= 1'b0;
        else        rst_req_q <= wd_fire;
    end

    // Purpose: select the read value for the decoded offset.
    always_comb begin
        case (dec.kind)
            RS_MATCH:  rd_mux = match_q[dec.ch[CH_W-1:0]];
            RS_COUNT:  rd_mux = cnt_q;
            RS_STATUS: rd_mux = {{(DATA_W-NUM_CH){1'b0}}, stat_q};
            RS_WDOG:   rd_mux = wdog_q;
            RS_IEN:    rd_mux = {{(DATA_W-IEN_W){1'b0}}, ien_q};
            default:   rd_mux = '0;
        endcase
    end

    // Purpose: register read data and the unmapped-access flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            rdata_q <= acc_rd ? rd_mux : '0;
            err_q   <= bus_sel && (dec.kind == RS_NONE);
        end
    end

    assign bus_rdata = rdata_q;
    assign bus_err   = err_q;
    assign irq       = stat_q;
    assign rst_req   = rst_req_q;

endmodule

// File: rtl/ostm_timer_chk.sv
// Module ostm_timer_chk: protocol and state checks for ostm_timer, attached
// with bind. Reads only top-level ports and three internal registers.
module ostm_timer_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int NUM_CH = 4,
    parameter int IEN_W  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_err,
    input logic [NUM_CH-1:0] irq,
    input logic              rst_req,
    input logic [DATA_W-1:0] cnt_q,
    input logic [IEN_W-1:0]  ien_q,
    input logic [DATA_W-1:0] wdog_q
);

    logic cnt_wr;
    logic stat_wr;
    assign cnt_wr  = bus_sel && bus_wr && (bus_addr == ADDR_W'(8'h10));
    assign stat_wr = bus_sel && bus_wr && (bus_addr == ADDR_W'(8'h14));

    AST_RST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req); // R8
    AST_RST_REQ_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (wdog_q[0] == 1'b0)); // R8
    AST_CNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_wr) |=> $stable(cnt_q)); // R2
    AST_CNT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt_q == $past(bus_wdata))); // R3
    AST_ERR_FOLLOWS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_sel)); // R9
    AST_ERR_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (bus_rdata == '0)); // R9

    for (genvar k = 0; k < NUM_CH; k++) begin : g_irq
        AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq[k]) |-> $past(ien_q[k])); // R4
        AST_IRQ_FALL_BY_W1C: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(irq[k]) |-> $past(stat_wr && bus_wdata[k])); // R6
    end

endmodule

bind ostm_timer ostm_timer_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .NUM_CH (NUM_CH),
    .IEN_W  (IEN_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_err   (bus_err),
    .irq       (irq),
    .rst_req   (rst_req),
    .cnt_q     (cnt_q),
    .ien_q     (ien_q),
    .wdog_q    (wdog_q)
);

// File: tb/ostm_timer_tb.sv
// Bench for ostm_timer: a behavioural model built from the requirements,
// driven by directed corner cases and seeded random operations.
module ostm_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick;
    logic        bus_sel;
    logic        bus_wr;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [3:0]  irq;
    logic        rst_req;

    always #10 clk = ~clk;

    ostm_timer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_err   (bus_err),
        .irq       (irq),
        .rst_req   (rst_req)
    );

    int checks = 0;
    int errors = 0;

    logic [31:0] m_cnt;
    logic [31:0] m_match [4];
    logic [31:0] m_wdog;
    logic [11:0] m_ien;
    logic [3:0]  m_stat;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic is_mapped(input logic [7:0] a);
        return (a[1:0] == 2'b00) && (a <= 8'h1C);
    endfunction

    function automatic logic [31:0] model_read(input logic [7:0] a);
        if (!is_mapped(a)) return 32'h0;
        if (a < 8'h10) return m_match[a[3:2]];
        case (a)
            8'h10:   return m_cnt;
            8'h14:   return {28'h0, m_stat};
            8'h18:   return m_wdog;
            default: return {20'h0, m_ien};
        endcase
    endfunction

    // One bus cycle with optional tick; model updated, outputs checked after the edge.
    task automatic step(input string tag, input logic t, input logic s, input logic w,
                        input logic [7:0] a, input logic [31:0] d);
        logic [31:0] nx;
        logic        upd;
        logic [3:0]  fire;
        logic        rst_exp;
        logic [31:0] rd_exp;
        logic        err_exp;
        logic        is_rd;
        is_rd   = s && !w;
        rd_exp  = is_rd ? model_read(a) : 32'h0;
        err_exp = s && !is_mapped(a);
        if (s && w && a == 8'h10) begin
            nx = d; upd = 1'b1;
        end else if (t) begin
            nx = m_cnt + 32'd1; upd = 1'b1;
        end else begin
            nx = m_cnt; upd = 1'b0;
        end
        for (int k = 0; k < 4; k++) fire[k] = upd && (nx == m_match[k]);
        rst_exp = fire[3] && m_wdog[0];
        tick = t; bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        if (s && w && is_mapped(a)) begin
            if (a < 8'h10)       m_match[a[3:2]] = d;
            else if (a == 8'h14) m_stat = m_stat & ~d[3:0];
            else if (a == 8'h18) m_wdog = d;
            else if (a == 8'h1C) m_ien = d[11:0];
        end
        m_stat = m_stat | (fire & m_ien[3:0]);
        if (rst_exp) m_wdog = 32'h0;
        m_cnt = nx;
        @(negedge clk);
        tick = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        check("R5 irq", {28'h0, irq}, {28'h0, m_stat});
        check("R8 rst_req", {31'h0, rst_req}, {31'h0, rst_exp});
        if (s) check("R9 bus_err", {31'h0, bus_err}, {31'h0, err_exp});
        if (is_rd) check(tag, bus_rdata, rd_exp);
    endtask

    task automatic wr(input string tag, input logic [7:0] a, input logic [31:0] d);
        step(tag, 1'b0, 1'b1, 1'b1, a, d);
    endtask

    task automatic rd(input string tag, input logic [7:0] a);
        step(tag, 1'b0, 1'b1, 1'b0, a, 32'h0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step("R2 tick", 1'b1, 1'b0, 1'b0, 8'h0, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL timeout: run did not finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; tick = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        bus_addr = 8'h0; bus_wdata = 32'h0;
        m_cnt = 0; m_wdog = 0; m_ien = 0; m_stat = 0;
        for (int k = 0; k < 4; k++) m_match[k] = 0;
        repeat (3) @(negedge clk);
        check("R1 irq", {28'h0, irq}, 32'h0);
        check("R1 rst_req", {31'h0, rst_req}, 32'h0);
        check("R1 bus_err", {31'h0, bus_err}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int a = 0; a <= 8'h1C; a += 4) rd("R1 reset value", 8'(a));

        // R7: enable keeps low 12 bits
        wr("R7", 8'h1C, 32'hFFFF_FFFF);
        rd("R7 ien masked", 8'h1C);
        wr("R7", 8'h1C, 32'h0);

        // R2 count and hold, R10 read latency
        wr("R3", 8'h10, 32'd10);
        ticks(5);
        rd("R2 count", 8'h10);
        step("R2 idle", 1'b0, 1'b0, 1'b0, 8'h0, 32'h0);
        rd("R10 count hold", 8'h10);
        check("R10 rdata after idle", bus_rdata, bus_rdata);
        step("R10 idle", 1'b0, 1'b0, 1'b0, 8'h0, 32'h0);
        check("R10 rdata zero after idle", bus_rdata, 32'h0);

        // R2/R4 wrap with match at zero
        wr("R7", 8'h1C, 32'h2);
        wr("R4", 8'h04, 32'h0);
        wr("R3", 8'h10, 32'hFFFF_FFFF);
        ticks(1);
        rd("R2 wrap", 8'h10);
        rd("R4 wrap status", 8'h14);
        check("R4 wrap irq1", {28'h0, irq}, 32'h2);
        wr("R6", 8'h14, 32'h0);
        rd("R6 zero write no effect", 8'h14);
        wr("R6", 8'h14, 32'hF);
        rd("R6 cleared", 8'h14);
        check("R6 irq low", {28'h0, irq}, 32'h0);

        // R4 disabled channel
        wr("R7", 8'h1C, 32'h0);
        wr("R4", 8'h08, m_cnt + 32'd2);
        ticks(2);
        rd("R4 disabled no status", 8'h14);

        // R4 match write equal to current count does not fire
        wr("R7", 8'h1C, 32'h1);
        wr("R4", 8'h00, m_cnt);
        step("R4 idle", 1'b0, 1'b0, 1'b0, 8'h0, 32'h0);
        rd("R4 no fire on match write", 8'h14);

        // R4 fire via counter load
        wr("R4", 8'h00, 32'd777);
        wr("R3", 8'h10, 32'd777);
        rd("R4 fire by load", 8'h14);

        // R6 set wins over clear
        wr("R4", 8'h00, 32'd100);
        wr("R3", 8'h10, 32'd99);
        step("R6 collide", 1'b1, 1'b1, 1'b1, 8'h14, 32'h1);
        rd("R6 set wins", 8'h14);
        wr("R6", 8'h14, 32'h2);
        rd("R6 clear of unset bit", 8'h14);
        wr("R6", 8'h14, 32'h1);

        // R3 load wins over tick
        step("R3 load vs tick", 1'b1, 1'b1, 1'b1, 8'h10, 32'd500);
        rd("R3 loaded", 8'h10);
        ticks(3);
        rd("R3 continues", 8'h10);

        // R8 watchdog, armed then disarmed
        wr("R7", 8'h1C, 32'h0);
        wr("R8", 8'h18, 32'h1);
        wr("R8", 8'h0C, m_cnt + 32'd3);
        ticks(3);
        rd("R8 disarmed", 8'h18);
        check("R8 irq3 stays low", {31'h0, irq[3]}, 32'h0);
        wr("R8", 8'h0C, m_cnt + 32'd1);
        ticks(1);

        // R9 unmapped offsets
        rd("R9 read 0x24", 8'h24);
        rd("R9 read unaligned", 8'h02);
        rd("R9 read 0xFC", 8'hFC);
        wr("R9", 8'h20, 32'hDEAD_BEEF);
        wr("R9", 8'h11, 32'h1234_5678);
        for (int a = 0; a <= 8'h1C; a += 4) rd("R9 no register changed", 8'(a));

        // Random mix
        for (int i = 0; i < 600; i++) begin
            int op;
            op = $urandom_range(0, 11);
            case (op)
                0, 1, 2: ticks($urandom_range(1, 6));
                3: wr("R4", 8'(4 * $urandom_range(0, 3)), m_cnt + $urandom_range(1, 12));
                4: wr("R3", 8'h10, ($urandom_range(0, 3) == 0) ? m_match[$urandom_range(0, 3)]
                                                               : m_cnt + $urandom_range(0, 8));
                5: wr("R7", 8'h1C, $urandom());
                6: wr("R6", 8'h14, $urandom());
                7: wr("R8", 8'h18, {31'h0, 1'($urandom_range(0, 1))});
                8: step("R6", 1'b1, 1'b1, 1'b1, 8'h14, $urandom());
                9: rd("R9 random", 8'($urandom_range(0, 255)));
                default: rd("R10 random read", 8'(4 * $urandom_range(0, 7)));
            endcase
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule